// File: doc/BRIEF.md
# Strict-Priority Transmit Arbiter with Round-Robin Anti-Starvation

This block picks one of nine transmit clients per arbitration cycle. The clients have fixed IDs. ID 0 is management, ID 1 is debug traffic from the local port, ID 2 is debug traffic from the partner port, and IDs 3 to 8 carry traffic classes 0 to 5. A per-client select bit puts each client in one of two groups:

- **Strict group:** the client competes directly in a strict-priority arbiter. A priority map sets its level.
- **Round-robin group:** the client joins a round-robin group. The group winner competes at a fixed position below every strict level.

An external credit unit supplies a per-client blocking mask. A client with its blocking bit set cannot be granted, even while it requests.

A slot counter counts the strict grants issued since the last round-robin grant. When that count reaches the programmed gap, the next cycle serves the round-robin group if any member is eligible. This keeps low-priority traffic from starving. A gap of zero turns the block into a plain round-robin arbiter for its round-robin group.

The decision is registered. The one-hot grant and its valid strobe appear one clock after the inputs that produced them. The reset input is asynchronous and active low. It is expected to be released synchronously to the clock.

Top module: `prio_slot_arb`

## Requirements
- R1: A client is eligible only when its `req` bit is 1 and its `wfq_block` bit is 0. When no client is eligible, the next cycle shows `grant` = 0 and `grant_vld` = 0.
- R2: `grant` is registered and follows its inputs by one clock edge. At most one `grant` bit is 1, and `grant_vld` is 1 exactly when a `grant` bit is 1.
- R3: `prio_map` holds a 4-bit client ID per strict level. Bits [3:0] hold level 0, which is the highest, and bits [35:32] hold level 8. Among eligible strict clients (`strict_sel` bit = 1), the one mapped to the lowest level number wins. The setting 0x345678021 orders the clients 1, 2, 0, 8, 7, 6, 5, 4, 3.
- R4: A client with `strict_sel` bit = 0 never wins through a strict level. The round-robin group wins only when no strict client is eligible, unless a round-robin slot is due.
- R5: A round-robin slot is due when the number of strict grants since the last round-robin grant is at least `rr_slot_gap`. A due slot goes to the round-robin group when it has an eligible member.
- R6: With `rr_slot_gap` = 0, every cycle with an eligible round-robin member grants that group.
- R7: A due slot with no eligible round-robin member falls back to strict priority.
- R8: The slot count returns to zero on every round-robin grant, including a grant taken because no strict client was eligible.
- R9: The round-robin search starts at the client after the last round-robin winner and wraps from 8 to 0. The start point moves only on a round-robin grant.
- R10: After reset, `grant` = 0 and `grant_vld` = 0, the round-robin start point is client 0, and the slot count is 0.
- R11: A `prio_map` entry holding an ID of 9 or more matches no client, so that level is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 9 | Per-client request, bit index = client ID |
| wfq_block | input | 9 | Per-client blocking from the credit unit, 1 = blocked |
| strict_sel | input | 9 | 1 = client is in the strict group, 0 = round-robin group |
| prio_map | input | 36 | Client ID per strict level, 4 bits per level, level 0 in [3:0] |
| rr_slot_gap | input | 12 | Strict slots allowed between round-robin slots |
| grant | output | 9 | One-hot registered grant |
| grant_vld | output | 1 | Grant valid strobe |

## Verification
The bench builds the block with its default parameters: nine clients, 4-bit IDs and a 12-bit slot gap. These defaults reach every strict level of the map and both the wrap from client 8 to client 0 in the round-robin search. Small gap values (0 and 2) exercise the due, fallback and counter-reset paths within a few cycles. The largest gap (4095) keeps the arbiter in pure strict order during the map tests.

// File: rtl/prio_slot_arb_pkg.sv
package prio_slot_arb_pkg;
  localparam int unsigned DEF_CLIENTS = 9;
  localparam int unsigned DEF_SLOT_W  = 12;

  typedef enum logic [1:0] {
    PICK_NONE   = 2'd0,
    PICK_STRICT = 2'd1,
    PICK_RR     = 2'd2
  } pick_e;
endpackage

// File: rtl/prio_level_pick.sv
module prio_level_pick #(
  parameter int unsigned N_CL  = 9,
  parameter int unsigned CID_W = 4
) (
  input  logic [N_CL-1:0]       cand,
  input  logic [N_CL*CID_W-1:0] level_map,
  output logic                  hit,
  output logic [N_CL-1:0]       win
);
  logic [N_CL-1:0] match [N_CL];

  // each level matches at most the single client whose ID it holds
  for (genvar p = 0; p < N_CL; p++) begin : g_level
    for (genvar c = 0; c < N_CL; c++) begin : g_client
      assign match[p][c] = cand[c] &&
                           (level_map[p*CID_W +: CID_W] == CID_W'(c));
    end
  end

  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int p = N_CL - 1; p >= 0; p--) begin
      if (|match[p]) begin
        hit = 1'b1;
        win = match[p];
      end
    end
  end
endmodule

// File: rtl/rr_group_pick.sv
module rr_group_pick #(
  parameter int unsigned N_CL  = 9,
  parameter int unsigned PTR_W = 4
) (
  input  logic [N_CL-1:0]  cand,
  input  logic [PTR_W-1:0] start,
  output logic             hit,
  output logic [N_CL-1:0]  win,
  output logic [PTR_W-1:0] nxt_start
);
  logic [PTR_W:0]   idx;
  logic [PTR_W-1:0] win_idx;

  always_comb begin
    hit     = 1'b0;
    win     = '0;
    win_idx = '0;
    idx     = '0;
    for (int i = 0; i < N_CL; i++) begin
      idx = {1'b0, start} + (PTR_W+1)'(i);
      if (idx >= (PTR_W+1)'(N_CL)) idx = idx - (PTR_W+1)'(N_CL);
      if (!hit && cand[idx[PTR_W-1:0]]) begin
        hit     = 1'b1;
        win_idx = idx[PTR_W-1:0];
      end
    end
    if (hit) win[win_idx] = 1'b1;
    nxt_start = (win_idx == PTR_W'(N_CL - 1)) ? '0 : win_idx + 1'b1;
  end
endmodule

// File: rtl/slot_gap_ctrl.sv
module slot_gap_ctrl #(
  parameter int unsigned SLOT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] gap,
  input  logic              took_strict,
  input  logic              took_rr,
  output logic              rr_due
);
  logic [SLOT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign rr_due = (cnt_q >= gap);
  assign cnt_en = took_strict | took_rr;

  always_comb begin
    cnt_d = cnt_q;
    if (took_rr)                 cnt_d = '0;
    else if (cnt_q != '1)        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_en)  cnt_q <= cnt_d;
  end
endmodule

// File: rtl/prio_slot_arb.sv
module prio_slot_arb
  import prio_slot_arb_pkg::*;
#(
  parameter int unsigned N_CL   = DEF_CLIENTS,
  parameter int unsigned SLOT_W = DEF_SLOT_W,
  localparam int unsigned CID_W = $clog2(N_CL),
  localparam int unsigned PTR_W = $clog2(N_CL)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CL-1:0]       req,
  input  logic [N_CL-1:0]       wfq_block,
  input  logic [N_CL-1:0]       strict_sel,
  input  logic [N_CL*CID_W-1:0] prio_map,
  input  logic [SLOT_W-1:0]     rr_slot_gap,
  output logic [N_CL-1:0]       grant,
  output logic                  grant_vld
);
  logic [N_CL-1:0]  elig, sp_cand, rr_cand, sp_win, rr_win;
  logic             sp_hit, rr_hit, rr_due;
  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  pick_e            pick;
  logic [N_CL-1:0]  gnt_d, gnt_q;
  logic             vld_q;

  assign elig    = req & ~wfq_block;
  assign sp_cand = elig & strict_sel;
  assign rr_cand = elig & ~strict_sel;

  prio_level_pick #(.N_CL(N_CL), .CID_W(CID_W)) u_sp (
    .cand(sp_cand), .level_map(prio_map), .hit(sp_hit), .win(sp_win)
  );

  rr_group_pick #(.N_CL(N_CL), .PTR_W(PTR_W)) u_rr (
    .cand(rr_cand), .start(ptr_q), .hit(rr_hit), .win(rr_win),
    .nxt_start(ptr_nxt)
  );

  slot_gap_ctrl #(.SLOT_W(SLOT_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .gap(rr_slot_gap),
    .took_strict(pick == PICK_STRICT), .took_rr(pick == PICK_RR),
    .rr_due(rr_due)
  );

  always_comb begin
    if (rr_hit && (rr_due || !sp_hit)) pick = PICK_RR;
    else if (sp_hit)                   pick = PICK_STRICT;
    else                               pick = PICK_NONE;
    unique case (pick)
      PICK_RR:     gnt_d = rr_win;
      PICK_STRICT: gnt_d = sp_win;
      default:     gnt_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      gnt_q <= gnt_d;
      vld_q <= (pick != PICK_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ptr_q <= '0;
    else if (pick == PICK_RR) ptr_q <= ptr_nxt;
  end

  assign grant     = gnt_q;
  assign grant_vld = vld_q;
endmodule

// File: rtl/prio_slot_arb_chk.sv
module prio_slot_arb_chk #(
  parameter int unsigned N_CL   = 9,
  parameter int unsigned SLOT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_CL-1:0]   req,
  input logic [N_CL-1:0]   wfq_block,
  input logic [N_CL-1:0]   strict_sel,
  input logic [SLOT_W-1:0] rr_slot_gap,
  input logic [N_CL-1:0]   grant,
  input logic              grant_vld
);
  // R2: one-hot grant, strobe consistent with it
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r2_vld: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld == (grant != '0));
  // R1: no eligible client means no grant next cycle
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & ~wfq_block) == '0) |=> !grant_vld);
  // R1: a grant always goes to a client eligible one cycle earlier
  a_r1_elig: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> ((grant & $past(req & ~wfq_block)) != '0));
  // R6: zero gap always serves an eligible round-robin member
  a_r6_pure_rr: assert property (@(posedge clk) disable iff (!rst_n)
    ((rr_slot_gap == '0) && ((req & ~wfq_block & ~strict_sel) != '0))
      |=> ((grant & $past(~strict_sel)) != '0));
  // R10: outputs idle right after reset release
  a_r10_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (grant == '0 && !grant_vld));
endmodule

bind prio_slot_arb prio_slot_arb_chk #(.N_CL(N_CL), .SLOT_W(SLOT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .wfq_block(wfq_block),
  .strict_sel(strict_sel), .rr_slot_gap(rr_slot_gap),
  .grant(grant), .grant_vld(grant_vld)
);

// File: tb/prio_slot_arb_tb_top.sv
`timescale 1ns/1ps
module prio_slot_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  req, wfq_block, strict_sel;
  logic [35:0] prio_map;
  logic [11:0] rr_slot_gap;
  logic [8:0]  grant;
  logic        grant_vld;
  int          errors = 0;
  int          checks = 0;

  localparam logic [35:0] MAP_DEF = 36'h345678021;

  always #4 clk = ~clk;

  prio_slot_arb dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wfq_block(wfq_block),
    .strict_sel(strict_sel), .prio_map(prio_map),
    .rr_slot_gap(rr_slot_gap), .grant(grant), .grant_vld(grant_vld)
  );

  task automatic check(input string tag, input logic [8:0] exp_g,
                       input logic exp_v);
    checks++;
    if (grant !== exp_g || grant_vld !== exp_v) begin
      errors++;
      $display("FAIL %s: grant=%b vld=%b expected grant=%b vld=%b",
               tag, grant, grant_vld, exp_g, exp_v);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, check at next fall
  task automatic step(input logic [8:0] r, input logic [8:0] b,
                      input int exp_id, input string tag);
    req = r; wfq_block = b;
    @(negedge clk);
    if (exp_id < 0) check(tag, 9'd0, 1'b0);
    else            check(tag, 9'(1) << exp_id, 1'b1);
  endtask

  task automatic do_reset(input logic [8:0] ss, input logic [35:0] m,
                          input logic [11:0] gap);
    req = '0; wfq_block = '0; strict_sel = ss; prio_map = m;
    rr_slot_gap = gap;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(9'h1FF, MAP_DEF, 12'd4095);
    check("R10 idle after reset", 9'd0, 1'b0);
    step(9'h000, 9'h000, -1, "R1 no request");
  endtask

  task automatic t_strict_default;
    do_reset(9'h1FF, MAP_DEF, 12'd4095);
    step(9'b100001001, 9'h000, 0, "R3 mgmt over tc");
    step(9'b100001000, 9'h000, 8, "R3 tc5 over tc0");
    step(9'h1FF,       9'h000, 1, "R3 local debug top");
    step(9'b000000101, 9'h000, 2, "R3 partner debug over mgmt");
    step(9'b100001000, 9'h000, 8, "R2 one-hot single winner");
  endtask

  task automatic t_blocking;
    do_reset(9'h1FF, MAP_DEF, 12'd4095);
    step(9'b000000011, 9'b000000010, 0, "R1 blocked debug skipped");
    step(9'b000000011, 9'b000000011, -1, "R1 all blocked");
    step(9'b000010000, 9'b000000000, 4, "R1 unblocked again");
  endtask

  task automatic t_custom_map;
    do_reset(9'h1FF, 36'h876432105, 12'd4095);
    step(9'b000100001, 9'h000, 5, "R3 level0 holds client 5");
    step(9'b000000011, 9'h000, 0, "R3 level1 holds client 0");
    prio_map = 36'h87643210F;
    step(9'b000100001, 9'h000, 0, "R11 out-of-range ID skipped");
  endtask

  task automatic t_gap_two;
    do_reset(9'b000000111, MAP_DEF, 12'd2);
    step(9'h1FF, 9'h000, 1, "R5 strict slot 1");
    step(9'h1FF, 9'h000, 1, "R5 strict slot 2");
    step(9'h1FF, 9'h000, 3, "R5 rr slot due");
    step(9'h1FF, 9'h000, 1, "R8 count restarted");
    step(9'h1FF, 9'h000, 1, "R5 strict slot 2 again");
    step(9'h1FF, 9'h000, 4, "R9 pointer held over strict grants");
  endtask

  task automatic t_gap_zero;
    do_reset(9'b000000111, MAP_DEF, 12'd0);
    for (int k = 3; k <= 8; k++) step(9'h1FF, 9'h000, k, "R6 pure rr");
    step(9'h1FF, 9'h000, 3, "R9 wrap 8 to 0");
  endtask

  task automatic t_fallback;
    do_reset(9'b000000111, MAP_DEF, 12'd0);
    step(9'b000000100, 9'h000, 2, "R7 due slot falls back");
    step(9'b001000100, 9'h000, 6, "R6 rr member served");
    step(9'b001000100, 9'h000, 6, "R9 search wraps to same member");
  endtask

  task automatic t_count_reset;
    do_reset(9'b000000111, MAP_DEF, 12'd2);
    step(9'b000000010, 9'h000, 1, "R8 prep strict");
    step(9'b000100000, 9'h000, 5, "R4 rr when no strict");
    step(9'h1FF, 9'h000, 1, "R8 first strict after rr");
    step(9'h1FF, 9'h000, 1, "R8 second strict after rr");
    step(9'h1FF, 9'h000, 6, "R8 rr after gap, pointer after 5");
  endtask

  task automatic t_rr_lowest;
    do_reset(9'b000001000, MAP_DEF, 12'd4095);
    step(9'b100001000, 9'h000, 3, "R4 strict tc0 beats rr tc5");
    step(9'b100000000, 9'h000, 8, "R4 rr at lowest level");
    step(9'b100000001, 9'h000, 0, "R9 wrap after client 8");
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = '0; wfq_block = '0; strict_sel = '0;
    prio_map = MAP_DEF; rr_slot_gap = '0;
    @(negedge clk);
    t_reset();
    t_strict_default();
    t_blocking();
    t_custom_map();
    t_gap_two();
    t_gap_zero();
    t_fallback();
    t_count_reset();
    t_rr_lowest();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule